// File: doc/BRIEF.md
# Shared-Address Segment Register Loader (I2C write slave)

This block is a write-only I2C slave that fills eight 8-bit segment registers. Several copies of the block can sit on one bus under the same 7-bit slave address. Every copy acknowledges the address and latches the control byte that follows it. The control byte carries a drive-mode flag, a bank flag and a 6-bit pointer.

The upper pointer bits name one chip, and the lower three name a register inside that chip. Only the chip whose strapped subaddress matches the pointer stores the data bytes that follow and acknowledges them. After each data byte, every chip on the bus advances the pointer by the same amount: 2 in direct mode and 1 in duplex mode. A long burst therefore runs from one chip into the next with no new control byte.

The bus pins are sampled through a synchronizer on a fast system clock. The data line is driven only through a pull-low enable.

Top module: `segld_top`

## Requirements
- R1: The block acknowledges only the address byte 0x74 (7-bit address 0x3A, R/W bit 0). Any other first byte, including 0x75, gets no acknowledge, and the block ignores the rest of that transfer until the next START.
- R2: The byte after a matching address is loaded into the control state and acknowledged, whatever the subaddress pins say. Bit 7 is the duplex flag (`duplex_o`), bit 6 is the bank flag (`bank_o`), and bits 5..0 are the pointer (`vector_o`).
- R3: In direct mode (duplex flag 0), a data byte is stored and acknowledged only when pointer bits 5..3 equal `subaddr_i[2:0]`. It is then written to segment register pointer[2:0], which appears on `seg_o[8*k+7:8*k]`. On a mismatch the byte is neither stored nor acknowledged.
- R4: In duplex mode (duplex flag 1), pointer bit 5 and `subaddr_i[2]` are ignored. Selection compares only pointer bits 4..3 with `subaddr_i[1:0]`.
- R5: After every data byte the pointer advances by 2 in direct mode and by 1 in duplex mode. This happens whether or not the byte was selected.
- R6: The pointer wraps from 63 to 0. A transfer may carry any number of data bytes.
- R7: A STOP right after the control-byte acknowledge changes the control state and leaves every segment register unchanged.
- R8: An active-low reset clears the control state and all segment registers, and releases the data line.
- R9: A repeated START aborts the current transfer, even in the middle of a byte. The next byte is decoded as an address, and a partly received byte is discarded.
- R10: The acknowledge pull-low starts at the SCL falling edge after the eighth bit and ends at the next SCL falling edge. It is never asserted while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| subaddr_i | input | 3 | Strapped chip subaddress |
| sda_pull_o | output | 1 | Pull-low enable for the data line |
| seg_o | output | 64 | Eight segment registers, register k in bits 8k+7..8k |
| duplex_o | output | 1 | Drive-mode flag from control bit 7 |
| bank_o | output | 1 | Bank flag from control bit 6 |
| vector_o | output | 6 | Current chip/register pointer |

## Verification
A pointer that advances by the wrong step, or only on selected bytes, shows up on `vector_o` at the end of the same byte. It also changes which later byte of a burst gets acknowledged, so the ack pattern of a multi-byte transfer exposes it within one or two bytes. A wrong chip compare shows up at once as a missing or extra acknowledge, and as a segment register that does or does not take the byte. A receiver phase that is off by one byte, or that survives a repeated START, moves every later byte into the wrong role. That is visible in the very next acknowledge.

// File: rtl/segld_pkg.sv
package segld_pkg;
  // Role of the byte currently being shifted in.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CTRL = 2'd2,
    PH_DATA = 2'd3
  } phase_e;
endpackage

// File: rtl/segld_bus_sync.sv
module segld_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  localparam int LAST = STAGES;

  logic [LAST:0] scl_pipe_q, scl_pipe_d;
  logic [LAST:0] sda_pipe_q, sda_pipe_d;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[LAST-1:0], scl_i};
    sda_pipe_d = {sda_pipe_q[LAST-1:0], sda_i};
  end

  // Idle bus reads high, so the pipes reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now   = scl_pipe_q[LAST-1];
  assign scl_old   = scl_pipe_q[LAST];
  assign sda_now   = sda_pipe_q[LAST-1];
  assign sda_old   = sda_pipe_q[LAST];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
  assign sda_bit   = sda_now;
endmodule

// File: rtl/segld_byte_rx.sv
module segld_byte_rx
  import segld_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_bit,
  input  logic              ack_want,
  output logic              byte_stb,
  output logic [DATA_W-1:0] byte_o,
  output phase_e            phase_o,
  output logic              sda_pull_o
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pull_q, pull_d;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    pull_d   = pull_q;
    byte_stb = 1'b0;
    if (start_det) begin
      phase_d = PH_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise && (cnt_q < CNT_FULL)) begin
        sh_d  = {sh_q[DATA_W-2:0], sda_bit};
        cnt_d = cnt_q + 1'b1;
      end else if (scl_fall && (cnt_q == CNT_FULL)) begin
        // Byte complete: enter the acknowledge slot.
        byte_stb = 1'b1;
        pull_d   = ack_want;
        cnt_d    = CNT_ACK;
        if ((phase_q == PH_ADDR) && !ack_want) phase_d = PH_IDLE;
      end else if (scl_fall && (cnt_q == CNT_ACK)) begin
        pull_d = 1'b0;
        cnt_d  = '0;
        if (phase_q == PH_ADDR)      phase_d = PH_CTRL;
        else if (phase_q == PH_CTRL) phase_d = PH_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      pull_q  <= pull_d;
    end
  end

  assign byte_o     = sh_q;
  assign phase_o    = phase_q;
  assign sda_pull_o = pull_q;
endmodule

// File: rtl/segld_regfile.sv
module segld_regfile
  import segld_pkg::*;
#(
  parameter int          NUM_REGS   = 8,
  parameter int          SUB_W      = 3,
  parameter int          DATA_W     = 8,
  parameter logic [6:0]  SLAVE_ADDR = 7'h3A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_stb,
  input  logic [DATA_W-1:0]          byte_i,
  input  phase_e                     phase_i,
  input  logic [SUB_W-1:0]           subaddr_i,
  output logic                       ack_want,
  output logic [NUM_REGS*DATA_W-1:0] seg_o,
  output logic                       mode_o,
  output logic                       bank_o,
  output logic [SUB_W+$clog2(NUM_REGS)-1:0] vec_o
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int VEC_W = SUB_W + IDX_W;
  localparam int MODE_BIT = DATA_W - 1;
  localparam int BANK_BIT = DATA_W - 2;

  logic             mode_q, mode_d;
  logic             bank_q, bank_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [VEC_W-1:0] step;
  logic             addr_hit, chip_sel, ctrl_ld, data_ld;
  logic [IDX_W-1:0] idx;

  assign idx      = vec_q[IDX_W-1:0];
  assign addr_hit = (byte_i == {SLAVE_ADDR, 1'b0});
  // Duplex mode drops the top subaddress bit from the compare.
  assign chip_sel = mode_q ? (vec_q[VEC_W-2:IDX_W] == subaddr_i[SUB_W-2:0])
                           : (vec_q[VEC_W-1:IDX_W] == subaddr_i);
  assign step     = mode_q ? VEC_W'(1) : VEC_W'(2);
  assign ctrl_ld  = byte_stb && (phase_i == PH_CTRL);
  assign data_ld  = byte_stb && (phase_i == PH_DATA);

  always_comb begin
    unique case (phase_i)
      PH_ADDR: ack_want = addr_hit;
      PH_CTRL: ack_want = 1'b1;
      PH_DATA: ack_want = chip_sel;
      default: ack_want = 1'b0;
    endcase
  end

  always_comb begin
    mode_d = mode_q;
    bank_d = bank_q;
    vec_d  = vec_q;
    if (ctrl_ld) begin
      mode_d = byte_i[MODE_BIT];
      bank_d = byte_i[BANK_BIT];
      vec_d  = byte_i[VEC_W-1:0];
    end else if (data_ld) begin
      vec_d = vec_q + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      bank_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      mode_q <= mode_d;
      bank_q <= bank_d;
      vec_q  <= vec_d;
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_seg
    logic              wr_en;
    logic [DATA_W-1:0] seg_q;
    assign wr_en = data_ld && chip_sel && (idx == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     seg_q <= '0;
      else if (wr_en) seg_q <= byte_i;
    end
    assign seg_o[k*DATA_W +: DATA_W] = seg_q;
  end

  assign mode_o = mode_q;
  assign bank_o = bank_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/segld_top.sv
module segld_top
  import segld_pkg::*;
#(
  parameter int         NUM_REGS    = 8,
  parameter int         SUB_W       = 3,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] SLAVE_ADDR  = 7'h3A
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic [SUB_W-1:0]           subaddr_i,
  output logic                       sda_pull_o,
  output logic [NUM_REGS*DATA_W-1:0] seg_o,
  output logic                       duplex_o,
  output logic                       bank_o,
  output logic [SUB_W+$clog2(NUM_REGS)-1:0] vector_o
);
  // Reset asserts at once and releases on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic              byte_stb, ack_want;
  logic [DATA_W-1:0] rx_byte;
  phase_e            phase;

  segld_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_bit(sda_bit)
  );

  segld_byte_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .ack_want(ack_want), .byte_stb(byte_stb), .byte_o(rx_byte),
    .phase_o(phase), .sda_pull_o(sda_pull_o)
  );

  segld_regfile #(
    .NUM_REGS(NUM_REGS), .SUB_W(SUB_W), .DATA_W(DATA_W), .SLAVE_ADDR(SLAVE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .byte_stb(byte_stb), .byte_i(rx_byte),
    .phase_i(phase), .subaddr_i(subaddr_i), .ack_want(ack_want),
    .seg_o(seg_o), .mode_o(duplex_o), .bank_o(bank_o), .vec_o(vector_o)
  );
endmodule

// File: rtl/segld_checker.sv
module segld_checker
  import segld_pkg::*;
#(
  parameter int SEG_W  = 64,
  parameter int DATA_W = 8,
  parameter int VEC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic              byte_stb,
  input phase_e            phase,
  input logic [DATA_W-1:0] rx_byte,
  input logic              duplex_o,
  input logic              bank_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [SEG_W-1:0]  seg_o
);
  // R10: pull-low only ever begins while the clock line is low.
  a_r10_pull_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R10: pull-low only ever ends while the clock line is low.
  a_r10_pull_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> !scl_i);

  // R1: an idle receiver never drives the data line.
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull_o);

  // R2: a completed control byte appears on the control outputs next cycle.
  a_r2_ctrl_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && phase == PH_CTRL) |=>
      ({duplex_o, bank_o, vector_o} == $past(rx_byte[DATA_W-1 -: VEC_W+2])));

  // R5: each data byte moves the pointer by the mode's step.
  a_r5_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && phase == PH_DATA) |=>
      (vector_o == $past(vector_o) + ($past(duplex_o) ? VEC_W'(1) : VEC_W'(2))));

  // R7: segment registers move only after a completed data byte.
  a_r7_seg_only_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg_o) |-> $past(byte_stb && phase == PH_DATA));
endmodule

bind segld_top segld_checker #(
  .SEG_W(NUM_REGS*DATA_W), .DATA_W(DATA_W), .VEC_W(SUB_W+$clog2(NUM_REGS))
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .byte_stb(byte_stb), .phase(phase), .rx_byte(rx_byte),
  .duplex_o(duplex_o), .bank_o(bank_o), .vector_o(vector_o), .seg_o(seg_o)
);

// File: tb/segld_top_tb.sv
module segld_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic [2:0]  sub = 3'd0;
  logic        sda_pull;
  logic [63:0] seg;
  logic        duplex, bank;
  logic [5:0]  vec;
  wire         sda_line = sda_drv & ~sda_pull;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  segld_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .subaddr_i(sub), .sda_pull_o(sda_pull), .seg_o(seg),
    .duplex_o(duplex), .bank_o(bank), .vector_o(vec)
  );

  // Fields: sub[38:36] ctrl[35:28] data[27:20] ack[19] idx[18:16] val[15:8] ctrl_after[7:0]
  localparam int NV = 9;
  localparam logic [38:0] VECS [NV] = '{
    {3'd0, 8'h00, 8'hA5, 1'b1, 3'd0, 8'hA5, 8'h02},  // R3 direct hit
    {3'd0, 8'h03, 8'h3C, 1'b1, 3'd3, 8'h3C, 8'h05},  // R3 odd index
    {3'd0, 8'h08, 8'hFF, 1'b0, 3'd0, 8'hA5, 8'h0A},  // R3 miss, R5 still steps
    {3'd5, 8'h6E, 8'h81, 1'b1, 3'd6, 8'h81, 8'h70},  // R2 bank flag
    {3'd6, 8'h97, 8'h42, 1'b1, 3'd7, 8'h42, 8'h98},  // R4 bit5 ignored
    {3'd6, 8'h89, 8'h99, 1'b0, 3'd1, 8'h00, 8'h8A},  // R4 miss
    {3'd7, 8'h3E, 8'h5A, 1'b1, 3'd6, 8'h5A, 8'h00},  // R6 direct wrap
    {3'd6, 8'h12, 8'h77, 1'b0, 3'd2, 8'h00, 8'h14},  // R3 top bit compared
    {3'd7, 8'hBF, 8'h24, 1'b1, 3'd7, 8'h24, 8'h80}   // R6 duplex wrap
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b;    wq();
    scl_drv = 1'b1; wq(); wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    acked = ~sda_line;
    wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic        a;
    logic [63:0] snap;
    logic [7:0]  exp_seg [8];

    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8 seg after reset", seg, 64'h0);
    chk("R8 ctrl after reset", {56'h0, duplex, bank, vec}, 64'h0);
    chk("R8 pull after reset", {63'h0, sda_pull}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: one transfer each
    for (int v = 0; v < NV; v++) begin
      logic [38:0] t;
      t = VECS[v];
      sub = t[38:36];
      bus_start();
      put_byte(8'h74, a);
      chk("R1 address ack", {63'h0, a}, 64'h1);
      put_byte(t[35:28], a);
      chk("R2 control ack", {63'h0, a}, 64'h1);
      put_byte(t[27:20], a);
      chk("R3/R4 data ack", {63'h0, a}, {63'h0, t[19]});
      bus_stop();
      chk("R3/R4 register", {56'h0, seg[t[18:16]*8 +: 8]}, {56'h0, t[15:8]});
      chk("R5/R6 pointer", {56'h0, duplex, bank, vec}, {56'h0, t[7:0]});
    end

    // R1: foreign address and read bit ignored
    bus_start();
    put_byte(8'h76, a);
    chk("R1 foreign address nack", {63'h0, a}, 64'h0);
    put_byte(8'h5A, a);
    chk("R1 following byte ignored", {63'h0, a}, 64'h0);
    bus_stop();
    chk("R1 ctrl untouched", {56'h0, duplex, bank, vec}, 64'h80);
    bus_start();
    put_byte(8'h75, a);
    chk("R1 read bit nack", {63'h0, a}, 64'h0);
    bus_stop();

    // R7: control then STOP
    snap = seg;
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h40, a);
    bus_stop();
    chk("R7 bank set alone", {56'h0, duplex, bank, vec}, 64'h40);
    chk("R7 segments unchanged", seg, snap);

    // R2: control acked with foreign subaddress, data not
    sub = 3'd7;
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h00, a);
    chk("R2 ctrl ack on sub miss", {63'h0, a}, 64'h1);
    put_byte(8'h10, a);
    chk("R3 data nack on sub miss", {63'h0, a}, 64'h0);
    bus_stop();

    // R5/R6: duplex burst across a chip boundary
    sub = 3'd1;
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h88, a);
    for (int k = 0; k < 9; k++) begin
      put_byte(8'(8'h11 * (k + 1)), a);
      chk("R5 duplex burst ack", {63'h0, a}, {63'h0, (k < 8)});
    end
    bus_stop();
    for (int k = 0; k < 8; k++) exp_seg[k] = 8'(8'h11 * (k + 1));
    for (int k = 0; k < 8; k++)
      chk("R5 duplex burst register", {56'h0, seg[k*8 +: 8]}, {56'h0, exp_seg[k]});
    chk("R5 duplex pointer after", {56'h0, duplex, bank, vec}, 64'h91);

    // R5: direct burst touches odd registers, leaves chip after four
    sub = 3'd0;
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h01, a);
    for (int k = 0; k < 5; k++) begin
      put_byte(8'(8'hB0 + k), a);
      chk("R5 direct burst ack", {63'h0, a}, {63'h0, (k < 4)});
    end
    bus_stop();
    for (int k = 0; k < 4; k++) exp_seg[2*k+1] = 8'(8'hB0 + k);
    for (int k = 0; k < 8; k++)
      chk("R5 direct burst register", {56'h0, seg[k*8 +: 8]}, {56'h0, exp_seg[k]});
    chk("R5 direct pointer after", {56'h0, duplex, bank, vec}, 64'h0B);

    // R9: repeated START after a data byte restarts address decode
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h00, a);
    put_byte(8'hEE, a);
    bus_start();
    put_byte(8'h74, a);
    chk("R9 address after repeated start", {63'h0, a}, 64'h1);
    put_byte(8'h06, a);
    put_byte(8'h77, a);
    bus_stop();
    chk("R9 reg0 before restart", {56'h0, seg[7:0]}, 64'hEE);
    chk("R9 reg6 after restart", {56'h0, seg[55:48]}, 64'h77);

    // R9: partial byte aborted by repeated START
    bus_start();
    put_byte(8'h74, a);
    put_byte(8'h04, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    put_byte(8'h74, a);
    chk("R9 address after partial abort", {63'h0, a}, 64'h1);
    bus_stop();
    chk("R9 partial byte dropped", {56'h0, seg[39:32]}, {56'h0, exp_seg[4]});
    chk("R9 ctrl kept", {56'h0, duplex, bank, vec}, 64'h04);

    // R8: reset during operation
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 seg cleared", seg, 64'h0);
    chk("R8 ctrl cleared", {56'h0, duplex, bank, vec}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end
endmodule